// File: doc/BRIEF.md
# SPI Serial Static Memory Slave

This block is a byte-wide static memory that sits as a slave on an SPI bus in mode 0. A command is framed by the select line: the master pulls `spi_sel_n` low, shifts in an 8-bit opcode, and for memory accesses a 16-bit address. Data bytes then stream in on `mosi` or out on `miso`, and the command ends when `spi_sel_n` returns high. An internal address pointer steps after every data byte. A small mode register decides how it steps: one byte per command, wrapping inside a 32-byte page, or running across the whole array.

The SPI pins are resampled in the `clk` domain through a two-stage synchronizer, and SCK edges are found there. Each SCK phase must therefore last several `clk` cycles, and the first SCK rise must come at least two `clk` cycles after select falls. The array holds 2^`ADDR_W` bytes. `ADDR_W` = 13 gives the full 8K-byte space, and the default of 11 gives 2K bytes. Address bits above `ADDR_W` are ignored.

The controller has these states: `ST_IDLE` (deselected), `ST_OPCODE`, `ST_ADDR`, `ST_WDATA`, `ST_RDATA`, `ST_MWRITE`, `ST_MREAD` and `ST_DRAIN` (selected, clocks ignored). Its transitions are as follows:
- Any state goes to `ST_IDLE` when select goes high.
- `ST_IDLE` goes to `ST_OPCODE` once select is low.
- After the eighth opcode bit, `ST_OPCODE` goes to `ST_ADDR` for 0x02 or 0x03, to `ST_MWRITE` for 0x01, to `ST_MREAD` for 0x05, and to `ST_DRAIN` for any other value.
- After the sixteenth address bit, `ST_ADDR` goes to `ST_WDATA` or `ST_RDATA`.
- `ST_WDATA` and `ST_RDATA` go to `ST_DRAIN` after one byte in the single-byte modes.
- `ST_MWRITE` and `ST_MREAD` go to `ST_DRAIN` after one byte.

Top module: `spi_sram_slave`

## Requirements
- R1: After reset, `miso_oe` is low and the mode register holds 00 (single-byte mode).
- R2: Raising `spi_sel_n` ends any command at once, including in the middle of a byte. A partly shifted data byte is not stored, `miso_oe` drops, and the next command is decoded from its first bit.
- R3: The first 8 bits after select falls are the opcode, sampled on rising SCK, MSB first. 0x02 is write, 0x03 is read, 0x01 writes the mode register and 0x05 reads it. Any other opcode changes no memory and never drives `miso_oe`.
- R4: The opcode of a memory access is followed by a 16-bit address, MSB first. Only its low `ADDR_W` bits select the byte.
- R5: In a write, each byte shifted in MSB first replaces the stored byte at the pointer. `miso_oe` stays low for the whole write command.
- R6: In a read, each byte leaves on `miso` MSB first. Each bit changes after a falling SCK edge and is valid at the next rising edge. The first bit follows the falling edge after the last address bit. `miso_oe` is high only during the data phases of reads and mode reads.
- R7: The mode register is loaded from bits [7:6] of the byte after 0x01: 00 selects single-byte, 10 selects page and 01 selects burst. 11 behaves as single-byte. Opcode 0x05 returns the mode bits in [7:6], with [5:0] zero.
- R8: In single-byte mode, only the first data byte of a command is stored or sent. Later clocks up to deselect store nothing and leave `miso_oe` low.
- R9: In page mode, the pointer steps within its 32-byte page after each byte, from offset 31 back to offset 0, for both reads and writes. The upper address bits never change.
- R10: In burst mode, the pointer steps through the whole array after each byte and wraps from the top address to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, used to sample the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_clk | input | 1 | Serial clock from the master, idle low |
| spi_sel_n | input | 1 | Active-low select; frames each command |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |
| miso_oe | output | 1 | Drive enable for `miso` |

## Verification
The assertions check on every cycle that:
- a memory write never happens while `miso` is driven;
- a select held high silences the block;
- page-mode steps keep the page bits and advance the offset modulo 32;
- burst steps add one modulo the array size;
- single-byte mode never stores two bytes for one address phase.

Only the bench scenarios can show that bytes arrive at the right addresses with the right values and bit order. They also show that reads and writes wrap, that unknown opcodes and aborted bytes leave memory unchanged, and that the mode register reads back what was written. The bench runs these over a 256-byte configuration: full-array burst sweeps and page writes in every page.

// File: rtl/spi_sram_pkg.sv
package spi_sram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR,
        ST_WDATA,
        ST_RDATA,
        ST_MWRITE,
        ST_MREAD,
        ST_DRAIN
    } ctrl_state_e;

    typedef enum logic [1:0] {
        MODE_WORD  = 2'b00,
        MODE_BURST = 2'b01,
        MODE_PAGE  = 2'b10,
        MODE_RSVD  = 2'b11
    } access_mode_e;

    localparam logic [7:0] OP_MODE_WR = 8'h01;
    localparam logic [7:0] OP_WRITE   = 8'h02;
    localparam logic [7:0] OP_READ    = 8'h03;
    localparam logic [7:0] OP_MODE_RD = 8'h05;

    localparam int PAGE_BITS = 5;

endpackage

// File: rtl/spi_sram_sync.sv
module spi_sram_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic sel_n_i,
    input  logic sdi_i,
    output logic sck_rise,
    output logic sck_fall,
    output logic sel_act,
    output logic sdi_s
);
    localparam int W = 3;
    // bit order {sdi, sel_n, sck}; select resets to deselected
    localparam logic [W-1:0] RST_VAL = 3'b010;

    logic [STAGES-1:0][W-1:0] chain;
    logic [W-1:0]             last;
    logic                     sck_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
            sck_d <= 1'b0;
        end else begin
            chain[0] <= {sdi_i, sel_n_i, sck_i};
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
            sck_d <= last[0];
        end
    end

    assign last     = chain[STAGES-1];
    assign sck_rise = last[0] & ~sck_d;
    assign sck_fall = ~last[0] & sck_d;
    assign sel_act  = ~last[1];
    assign sdi_s    = last[2];

endmodule

// File: rtl/spi_sram_ptr.sv
module spi_sram_ptr
    import spi_sram_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              adv,
    input  access_mode_e      mode,
    output logic [ADDR_W-1:0] ptr
);
    logic [ADDR_W-1:0] nxt_lin;
    logic [ADDR_W-1:0] nxt_page;

    assign nxt_lin = ptr + 1'b1;

    generate
        if (ADDR_W > PAGE_BITS) begin : g_paged
            assign nxt_page = {ptr[ADDR_W-1:PAGE_BITS], ptr[PAGE_BITS-1:0] + 1'b1};
        end else begin : g_flat
            assign nxt_page = nxt_lin;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (load) begin
            ptr <= load_val;
        end else if (adv) begin
            ptr <= (mode == MODE_PAGE) ? nxt_page : nxt_lin;
        end
    end

endmodule

// File: rtl/spi_sram_mem.sv
module spi_sram_mem #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[addr] <= wdata;
    end

    assign rdata = cells[addr];

endmodule

// File: rtl/spi_sram_ctrl.sv
module spi_sram_ctrl
    import spi_sram_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_act,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              sdi_s,
    input  logic [7:0]        mem_rdata,
    output logic              ptr_load,
    output logic [ADDR_W-1:0] ptr_load_val,
    output logic              ptr_adv,
    output logic              mem_we,
    output logic [7:0]        mem_wdata,
    output access_mode_e      mode,
    output logic              sdo,
    output logic              sdo_oe
);
    localparam int WIN_W = (ADDR_W > 8) ? ADDR_W : 8;

    ctrl_state_e      st, st_n;
    logic [3:0]       cnt;
    logic [WIN_W-2:0] sh;
    logic [WIN_W-1:0] word_in;
    logic             is_read;
    logic             reload;
    logic [7:0]       tx;
    logic             bit_done;
    logic             single;

    assign word_in  = {sh, sdi_s};
    assign bit_done = sck_rise && (cnt == ((st == ST_ADDR) ? 4'd15 : 4'd7));
    assign single   = (mode == MODE_WORD) || (mode == MODE_RSVD);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_n;
    end

    // next state
    always_comb begin
        st_n = st;
        if (!sel_act) begin
            st_n = ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE:   st_n = ST_OPCODE;
                ST_OPCODE: if (bit_done) begin
                    case (word_in[7:0])
                        OP_WRITE, OP_READ: st_n = ST_ADDR;
                        OP_MODE_WR:        st_n = ST_MWRITE;
                        OP_MODE_RD:        st_n = ST_MREAD;
                        default:           st_n = ST_DRAIN;
                    endcase
                end
                ST_ADDR:   if (bit_done) st_n = is_read ? ST_RDATA : ST_WDATA;
                ST_WDATA,
                ST_RDATA:  if (bit_done && single) st_n = ST_DRAIN;
                ST_MWRITE,
                ST_MREAD:  if (bit_done) st_n = ST_DRAIN;
                ST_DRAIN:  st_n = ST_DRAIN;
                default:   st_n = ST_IDLE;
            endcase
        end
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            sh      <= '0;
            is_read <= 1'b0;
            reload  <= 1'b0;
            tx      <= '0;
            mode    <= MODE_WORD;
        end else begin
            if ((st_n != st) || bit_done)        cnt <= '0;
            else if (sck_rise && st != ST_IDLE)  cnt <= cnt + 4'd1;

            if (sck_rise) sh <= word_in[WIN_W-2:0];

            if (st == ST_OPCODE && bit_done) is_read <= (word_in[7:0] == OP_READ);

            if (st == ST_MWRITE && bit_done) mode <= access_mode_e'(word_in[7:6]);

            if (st == ST_IDLE) begin
                reload <= 1'b0;
            end else if ((st == ST_ADDR && bit_done && is_read) ||
                         (st == ST_OPCODE && bit_done && word_in[7:0] == OP_MODE_RD) ||
                         (st == ST_RDATA && bit_done)) begin
                reload <= 1'b1;
            end else if (sck_fall && reload) begin
                reload <= 1'b0;
            end

            if (sck_fall) begin
                if (reload) tx <= (st == ST_MREAD) ? {mode, 6'b0} : mem_rdata;
                else        tx <= {tx[6:0], 1'b0};
            end
        end
    end

    // outputs
    always_comb begin
        sdo          = tx[7];
        sdo_oe       = (st == ST_RDATA) || (st == ST_MREAD);
        mem_we       = (st == ST_WDATA) && bit_done;
        mem_wdata    = word_in[7:0];
        ptr_load     = (st == ST_ADDR) && bit_done;
        ptr_load_val = word_in[ADDR_W-1:0];
        ptr_adv      = ((st == ST_WDATA) || (st == ST_RDATA)) && bit_done;
    end

endmodule

// File: rtl/spi_sram_slave.sv
module spi_sram_slave
    import spi_sram_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_clk,
    input  logic spi_sel_n,
    input  logic mosi,
    output logic miso,
    output logic miso_oe
);
    logic              sck_rise, sck_fall, sel_act, sdi_s;
    logic              ptr_load, ptr_adv, mem_we;
    logic [ADDR_W-1:0] ptr_load_val, ptr;
    logic [7:0]        mem_wdata, mem_rdata;
    access_mode_e      mode;

    spi_sram_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_i    (spi_clk),
        .sel_n_i  (spi_sel_n),
        .sdi_i    (mosi),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .sel_act  (sel_act),
        .sdi_s    (sdi_s)
    );

    spi_sram_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .sel_act      (sel_act),
        .sck_rise     (sck_rise),
        .sck_fall     (sck_fall),
        .sdi_s        (sdi_s),
        .mem_rdata    (mem_rdata),
        .ptr_load     (ptr_load),
        .ptr_load_val (ptr_load_val),
        .ptr_adv      (ptr_adv),
        .mem_we       (mem_we),
        .mem_wdata    (mem_wdata),
        .mode         (mode),
        .sdo          (miso),
        .sdo_oe       (miso_oe)
    );

    spi_sram_ptr #(.ADDR_W(ADDR_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ptr_load),
        .load_val (ptr_load_val),
        .adv      (ptr_adv),
        .mode     (mode),
        .ptr      (ptr)
    );

    spi_sram_mem #(.ADDR_W(ADDR_W)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .addr  (ptr),
        .wdata (mem_wdata),
        .rdata (mem_rdata)
    );

endmodule

// File: rtl/spi_sram_chk.sv
module spi_sram_chk
    import spi_sram_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              spi_sel_n,
    input logic              miso_oe,
    input logic              mem_we,
    input logic              ptr_load,
    input logic              ptr_adv,
    input logic [ADDR_W-1:0] ptr,
    input access_mode_e      mode
);
    logic [ADDR_W-1:0]          ptr_inc;
    logic [PAGE_BITS-1:0]       low_inc;
    logic [1:0]                 wr_cnt;
    access_mode_e               mode_q;

    assign ptr_inc = ptr + 1'b1;
    assign low_inc = ptr[PAGE_BITS-1:0] + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_cnt <= '0;
            mode_q <= MODE_WORD;
        end else begin
            mode_q <= mode;
            if (ptr_load || mode != mode_q) wr_cnt <= '0;
            else if (mem_we && wr_cnt != 2'd3) wr_cnt <= wr_cnt + 2'd1;
        end
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (!miso_oe && mode == MODE_WORD));

    p_deselect_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sel_n && $past(spi_sel_n) && $past(spi_sel_n, 2) && $past(spi_sel_n, 3))
        |-> (!miso_oe && !mem_we));

    p_write_no_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !miso_oe);

    p_single_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_WORD || mode == MODE_RSVD) |-> (wr_cnt <= 2'd1));

    p_page_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_adv && mode == MODE_PAGE) |=>
        (ptr[ADDR_W-1:PAGE_BITS] == $past(ptr[ADDR_W-1:PAGE_BITS]) &&
         ptr[PAGE_BITS-1:0] == $past(low_inc)));

    p_burst_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_adv && mode == MODE_BURST) |=> (ptr == $past(ptr_inc)));

endmodule

bind spi_sram_slave spi_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .spi_sel_n (spi_sel_n),
    .miso_oe   (miso_oe),
    .mem_we    (mem_we),
    .ptr_load  (ptr_load),
    .ptr_adv   (ptr_adv),
    .ptr       (ptr),
    .mode      (mode)
);

// File: tb/spi_sram_slave_tb.sv
module spi_sram_slave_tb;
    localparam int AW    = 8;
    localparam int DEPTH = 1 << AW;
    localparam int HP    = 6;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n, spi_clk, spi_sel_n, mosi;
    logic miso, miso_oe;

    int   n_chk = 0;
    int   n_fail = 0;
    logic oe_seen;
    logic [7:0] exp_mem [DEPTH];
    logic [7:0] rx;

    spi_sram_slave #(.ADDR_W(AW)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .spi_clk   (spi_clk),
        .spi_sel_n (spi_sel_n),
        .mosi      (mosi),
        .miso      (miso),
        .miso_oe   (miso_oe)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, expv);
        end
    endtask

    task automatic send_bit(input logic b, output logic r);
        mosi = b;
        tick(HP);
        r = miso;
        if (miso_oe) oe_seen = 1'b1;
        spi_clk = 1'b1;
        tick(HP);
        spi_clk = 1'b0;
    endtask

    task automatic xfer(input logic [7:0] t, output logic [7:0] r);
        for (int b = 7; b >= 0; b--) send_bit(t[b], r[b]);
    endtask

    task automatic sel_on();
        oe_seen = 1'b0;
        spi_sel_n = 1'b0;
        tick(HP);
    endtask

    task automatic sel_off();
        tick(HP);
        spi_sel_n = 1'b1;
        tick(10);
    endtask

    task automatic cmd_addr(input logic [7:0] op, input logic [15:0] a);
        logic [7:0] d;
        xfer(op, d);
        xfer(a[15:8], d);
        xfer(a[7:0], d);
    endtask

    task automatic mode_wr(input logic [7:0] v);
        logic [7:0] d;
        sel_on(); xfer(8'h01, d); xfer(v, d); sel_off();
    endtask

    task automatic mode_rd(output logic [7:0] v);
        logic [7:0] d;
        sel_on(); xfer(8'h05, d); xfer(8'h00, v); sel_off();
    endtask

    task automatic read1(input logic [15:0] a, output logic [7:0] v);
        sel_on(); cmd_addr(8'h03, a); xfer(8'h00, v); sel_off();
    endtask

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'((i * 37 + seed * 11 + 5) ^ (i >> 3));
    endfunction

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R2 watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        rst_n = 1'b0; spi_clk = 1'b0; spi_sel_n = 1'b1; mosi = 1'b0; oe_seen = 1'b0;
        tick(10);
        rst_n = 1'b1;
        tick(5);

        // R1: reset state
        chk8("R1 miso_oe after reset", {7'b0, miso_oe}, 8'h00);
        mode_rd(d);
        chk8("R1 mode after reset", d, 8'h00);
        chk8("R6 miso_oe during mode read", {7'b0, oe_seen}, 8'h01);

        // R7, R10: burst fill of the whole array, start 0x80, upper bits set (R4)
        mode_wr(8'h40);
        mode_rd(d);
        chk8("R7 mode readback burst", d, 8'h40);
        sel_on();
        cmd_addr(8'h02, 16'hFF80);
        for (int i = 0; i < DEPTH + 2; i++) begin
            logic [7:0] v;
            v = pat(1, i);
            xfer(v, d);
            exp_mem[(128 + i) % DEPTH] = v;
        end
        sel_off();
        chk8("R5 miso_oe low during write", {7'b0, oe_seen}, 8'h00);

        // R10: burst read sweep past the top address
        sel_on();
        cmd_addr(8'h03, 16'h0000);
        for (int i = 0; i < DEPTH + 2; i++) begin
            xfer(8'h00, d);
            chk8($sformatf("R10 burst read %0d", i), d, exp_mem[i % DEPTH]);
        end
        sel_off();
        chk8("R6 miso_oe high during read", {7'b0, oe_seen}, 8'h01);
        chk8("R2 miso_oe low after deselect", {7'b0, miso_oe}, 8'h00);

        // R8, R4, R5: single-byte mode
        mode_wr(8'h00);
        sel_on();
        cmd_addr(8'h02, 16'h1234);
        xfer(8'hA1, d); xfer(8'hB2, d); xfer(8'hC3, d);
        sel_off();
        exp_mem[8'h34] = 8'hA1;
        read1(16'h0034, d);
        chk8("R4 upper address bits ignored", d, 8'hA1);
        read1(16'h0035, d);
        chk8("R8 extra write bytes ignored", d, exp_mem[8'h35]);
        sel_on();
        cmd_addr(8'h03, 16'h0034);
        xfer(8'h00, d);
        chk8("R5 single read returns written byte", d, 8'hA1);
        oe_seen = 1'b0;
        xfer(8'h00, d);
        sel_off();
        chk8("R8 miso_oe low after first byte", {7'b0, oe_seen}, 8'h00);

        // R9: page writes in every page, 40 bytes each, wrap within page
        mode_wr(8'h80);
        for (int p = 0; p < DEPTH / 32; p++) begin
            int off;
            off = (p * 5) % 32;
            sel_on();
            cmd_addr(8'h02, 16'(p * 32 + off));
            for (int i = 0; i < 40; i++) begin
                logic [7:0] v;
                v = pat(p + 3, i);
                xfer(v, d);
                exp_mem[p * 32 + ((off + i) % 32)] = v;
            end
            sel_off();
        end
        sel_on();
        cmd_addr(8'h03, 16'h005E);
        for (int i = 0; i < 4; i++) begin
            xfer(8'h00, d);
            chk8($sformatf("R9 page read wrap %0d", i), d, exp_mem[8'h40 + ((30 + i) % 32)]);
        end
        sel_off();

        // R7: reserved mode code acts as single-byte
        mode_wr(8'hC0);
        mode_rd(d);
        chk8("R7 mode readback reserved", d, 8'hC0);
        sel_on();
        cmd_addr(8'h02, 16'h0050);
        xfer(8'h11, d); xfer(8'h22, d);
        sel_off();
        exp_mem[8'h50] = 8'h11;
        read1(16'h0051, d);
        chk8("R7 reserved mode stores one byte", d, exp_mem[8'h51]);
        mode_wr(8'h00);

        // R2: abort in the middle of a data byte
        sel_on();
        cmd_addr(8'h02, 16'h0060);
        for (int b = 0; b < 4; b++) begin
            logic r;
            send_bit(1'b1, r);
        end
        sel_off();
        read1(16'h0060, d);
        chk8("R2 partial byte not stored", d, exp_mem[8'h60]);

        // R3: unknown opcode
        sel_on();
        xfer(8'hA5, d); xfer(8'h02, d); xfer(8'h00, d); xfer(8'h70, d); xfer(8'h5A, d);
        sel_off();
        chk8("R3 unknown opcode never drives", {7'b0, oe_seen}, 8'h00);
        read1(16'h0070, d);
        chk8("R3 unknown opcode stores nothing", d, exp_mem[8'h70]);

        // R5, R10: final full-array check in burst mode
        mode_wr(8'h40);
        sel_on();
        cmd_addr(8'h03, 16'h0000);
        for (int i = 0; i < DEPTH; i++) begin
            xfer(8'h00, d);
            chk8($sformatf("R5 final contents %0d", i), d, exp_mem[i]);
        end
        sel_off();

        finish_run();
    end

endmodule